// File: doc/BRIEF.md
# Segment Base-Limit Address Translator

This unit turns a logical address into a physical one for a segmented memory system. A logical address is a segment number paired with an offset inside that segment. The unit keeps a small table with one entry per segment number. Each entry holds a limit, a base and two attribute bits: a presence bit and a read-only bit. For each request it reads the entry, checks that the offset is strictly below the limit, and returns base plus offset. When a check fails it returns a fault code and no address.

Privileged software fills the table through a dedicated write port. When several tasks share one code segment, each of their tables gives that segment the same number and marks it read-only. A write through that segment then raises a protection fault. Reads through it translate normally.

The result is registered. The unit accepts one request per cycle and returns the answer one cycle later. The fault code, the error flag and the address are valid in the same cycle.

Top module: `seg_xlat`

## Requirements
- R1: After reset `rsp_valid` is low and every table entry is absent, so any lookup before a table load returns fault code 3.
- R2: A request with `req_valid` high in cycle N gives `rsp_valid` high in cycle N+1. In a cycle after no request, `rsp_valid` is low.
- R3: When the entry is present, `req_off < limit`, and the request is not a write to a read-only entry, the response has fault code 0. `rsp_addr` is then base + offset, zero-extended to BASE_W+1 bits. Example: base 3500, limit 2000 and offset 1123 give 4623.
- R4: An offset greater than or equal to the limit gives fault code 1. A limit of 0 makes every offset fault.
- R5: A write request (`req_write` = 1) to an entry whose read-only bit is set gives fault code 2. A read of the same entry translates normally.
- R6: A lookup of an entry whose presence bit is clear gives fault code 3, for reads and for writes alike.
- R7: When more than one fault applies, the reported code follows this priority: absent (3) first, then limit (1), then protection (2).
- R8: A table write takes effect at the clock edge. A lookup of the same segment in the same cycle sees the old contents. A lookup in the next cycle sees the new contents.
- R9: `rsp_err` is high exactly when the registered fault code is nonzero. `rsp_addr` is zero whenever `rsp_err` is high or `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_seg | input | SEG_W | Segment number of the request |
| req_off | input | OFF_W | Offset within the segment |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_seg | input | SEG_W | Entry to write |
| tbl_limit | input | OFF_W+1 | New limit value |
| tbl_base | input | BASE_W | New base value |
| tbl_live | input | 1 | New presence bit |
| tbl_ro | input | 1 | New read-only bit |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 2 | 0 ok, 1 limit, 2 protection, 3 absent |
| rsp_err | output | 1 | Any fault |
| rsp_addr | output | BASE_W+1 | Physical address, zero on fault |

## Verification
The bench probes offsets at limit-1, at the limit and at the top of the offset range. A design that used `<=` instead of `<`, or that truncated the offset, would pass the access at the limit or wrap the address.

It also sets up requests where several faults apply at once: a write to an absent entry and a write past the limit of a read-only entry. A design with the wrong priority would report the wrong code.

The bench loads an entry and looks it up in the same cycle. A table that forwarded the write would return the new entry one cycle too early. Randomized traffic also confirms that reads of read-only segments never fault and that the base-plus-offset sum carries into the top bit.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_LIMIT   = 2'd1,
        FLT_PROT    = 2'd2,
        FLT_ABSENT  = 2'd3
    } fault_e;

    typedef struct packed {
        logic ro;
        logic live;
    } seg_attr_t;

endpackage

// File: rtl/seg_table.sv
module seg_table
    import seg_xlat_pkg::*;
#(
    parameter int SEG_W  = 2,
    parameter int LIM_W  = 13,
    parameter int BASE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEG_W-1:0]  wr_seg,
    input  logic [LIM_W-1:0]  wr_limit,
    input  logic [BASE_W-1:0] wr_base,
    input  seg_attr_t         wr_attr,
    input  logic [SEG_W-1:0]  rd_seg,
    output logic [LIM_W-1:0]  rd_limit,
    output logic [BASE_W-1:0] rd_base,
    output seg_attr_t         rd_attr
);

    localparam int NSEG = 1 << SEG_W;

    typedef struct packed {
        logic [LIM_W-1:0]  limit;
        logic [BASE_W-1:0] base;
        seg_attr_t         attr;
    } entry_t;

    entry_t [NSEG-1:0] tab_d, tab_q;
    logic   [NSEG-1:0] wr_hit;
    entry_t            wr_entry;

    assign wr_entry = '{limit: wr_limit, base: wr_base, attr: wr_attr};

    for (genvar g = 0; g < NSEG; g++) begin : g_dec
        assign wr_hit[g] = wr_en && (wr_seg == SEG_W'(g));
    end

    always_comb begin
        tab_d = tab_q;
        for (int i = 0; i < NSEG; i++) begin
            if (wr_hit[i]) tab_d[i] = wr_entry;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tab_q <= '0;
        else        tab_q <= tab_d;
    end

    // Reads come from the registered table, so a same-cycle write is not seen.
    assign rd_limit = tab_q[rd_seg].limit;
    assign rd_base  = tab_q[rd_seg].base;
    assign rd_attr  = tab_q[rd_seg].attr;

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlat_pkg::*;
#(
    parameter int OFF_W  = 12,
    parameter int LIM_W  = 13,
    parameter int BASE_W = 16,
    parameter int PA_W   = 17
) (
    input  logic [LIM_W-1:0]  limit,
    input  logic [BASE_W-1:0] base,
    input  seg_attr_t         attr,
    input  logic [OFF_W-1:0]  off,
    input  logic              is_write,
    output fault_e            fault,
    output logic [PA_W-1:0]   addr
);

    logic in_range;

    assign in_range = LIM_W'(off) < limit;
    assign addr     = PA_W'(base) + PA_W'(off);

    // Priority: absent entry, then limit, then write protection.
    always_comb begin
        if (!attr.live)              fault = FLT_ABSENT;
        else if (!in_range)          fault = FLT_LIMIT;
        else if (is_write && attr.ro) fault = FLT_PROT;
        else                         fault = FLT_NONE;
    end

endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
    import seg_xlat_pkg::*;
#(
    parameter int SEG_W  = 2,
    parameter int OFF_W  = 12,
    parameter int BASE_W = 16,
    localparam int LIM_W = OFF_W + 1,
    localparam int PA_W  = BASE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    input  logic              tbl_we,
    input  logic [SEG_W-1:0]  tbl_seg,
    input  logic [LIM_W-1:0]  tbl_limit,
    input  logic [BASE_W-1:0] tbl_base,
    input  logic              tbl_live,
    input  logic              tbl_ro,
    output logic              rsp_valid,
    output logic [1:0]        rsp_fault,
    output logic              rsp_err,
    output logic [PA_W-1:0]   rsp_addr
);

    typedef struct packed {
        logic            valid;
        fault_e          fault;
        logic [PA_W-1:0] addr;
    } rsp_t;

    rsp_t              rsp_d, rsp_q;
    logic [LIM_W-1:0]  ent_limit;
    logic [BASE_W-1:0] ent_base;
    seg_attr_t         ent_attr;
    fault_e            chk_fault;
    logic [PA_W-1:0]   chk_addr;

    seg_table #(.SEG_W(SEG_W), .LIM_W(LIM_W), .BASE_W(BASE_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_we),
        .wr_seg   (tbl_seg),
        .wr_limit (tbl_limit),
        .wr_base  (tbl_base),
        .wr_attr  ('{ro: tbl_ro, live: tbl_live}),
        .rd_seg   (req_seg),
        .rd_limit (ent_limit),
        .rd_base  (ent_base),
        .rd_attr  (ent_attr)
    );

    seg_check #(.OFF_W(OFF_W), .LIM_W(LIM_W), .BASE_W(BASE_W), .PA_W(PA_W)) u_check (
        .limit    (ent_limit),
        .base     (ent_base),
        .attr     (ent_attr),
        .off      (req_off),
        .is_write (req_write),
        .fault    (chk_fault),
        .addr     (chk_addr)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        rsp_d.fault = FLT_NONE;
        if (req_valid) begin
            rsp_d.fault = chk_fault;
            if (chk_fault == FLT_NONE) rsp_d.addr = chk_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_fault = rsp_q.fault;
    assign rsp_err   = (rsp_q.fault != FLT_NONE);
    assign rsp_addr  = rsp_q.addr;

endmodule

// File: rtl/seg_xlat_chk.sv
module seg_xlat_chk #(
    parameter int PA_W = 17
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_write,
    input logic            rsp_valid,
    input logic [1:0]      rsp_fault,
    input logic            rsp_err,
    input logic [PA_W-1:0] rsp_addr
);

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R9
    addr_zero_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_addr == '0));

    // R9
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_err && rsp_addr == '0));

    // R5
    read_never_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> (rsp_fault != 2'd2));

endmodule

bind seg_xlat seg_xlat_chk #(.PA_W(PA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_err   (rsp_err),
    .rsp_addr  (rsp_addr)
);

// File: tb/seg_xlat_test.sv
module seg_xlat_test;

    localparam int SEG_W  = 2;
    localparam int OFF_W  = 12;
    localparam int BASE_W = 16;
    localparam int LIM_W  = OFF_W + 1;
    localparam int PA_W   = BASE_W + 1;
    localparam int NSEG   = 1 << SEG_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [SEG_W-1:0]  req_seg = '0;
    logic [OFF_W-1:0]  req_off = '0;
    logic              tbl_we = 1'b0;
    logic [SEG_W-1:0]  tbl_seg = '0;
    logic [LIM_W-1:0]  tbl_limit = '0;
    logic [BASE_W-1:0] tbl_base = '0;
    logic              tbl_live = 1'b0;
    logic              tbl_ro = 1'b0;
    logic              rsp_valid;
    logic [1:0]        rsp_fault;
    logic              rsp_err;
    logic [PA_W-1:0]   rsp_addr;

    int n_checks = 0;
    int n_errors = 0;

    int m_lim  [NSEG];
    int m_base [NSEG];
    bit m_live [NSEG];
    bit m_ro   [NSEG];

    always #5 clk = ~clk;

    seg_xlat #(.SEG_W(SEG_W), .OFF_W(OFF_W), .BASE_W(BASE_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_seg(req_seg), .req_off(req_off),
        .tbl_we(tbl_we), .tbl_seg(tbl_seg), .tbl_limit(tbl_limit), .tbl_base(tbl_base),
        .tbl_live(tbl_live), .tbl_ro(tbl_ro),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_err(rsp_err), .rsp_addr(rsp_addr)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    // One clock: drive at negedge, model the edge, compare at next negedge.
    task automatic step(input bit v, input bit w, input int seg, input int off,
                        input bit we, input int wseg, input int wlim, input int wbase,
                        input bit wlive, input bit wro, input string tag);
        int  e_fault;
        int  e_addr;
        bit  e_valid;
        string t;
        req_valid = v;   req_write = w;
        req_seg   = SEG_W'(seg);  req_off = OFF_W'(off);
        tbl_we    = we;  tbl_seg = SEG_W'(wseg);
        tbl_limit = LIM_W'(wlim); tbl_base = BASE_W'(wbase);
        tbl_live  = wlive; tbl_ro = wro;
        e_valid = v; e_fault = 0; e_addr = 0;
        if (v) begin
            if (!m_live[seg])                e_fault = 3;
            else if (off >= m_lim[seg])      e_fault = 1;
            else if (w && m_ro[seg])         e_fault = 2;
            else                             e_addr  = m_base[seg] + off;
        end
        @(posedge clk);
        if (we) begin
            m_lim[wseg] = wlim; m_base[wseg] = wbase;
            m_live[wseg] = wlive; m_ro[wseg] = wro;
        end
        @(negedge clk);
        t = tag;
        if (t == "") begin
            if (!e_valid)          t = "R2";
            else if (e_fault == 0) t = "R3";
            else if (e_fault == 1) t = "R4";
            else if (e_fault == 2) t = "R5";
            else                   t = "R6";
        end
        check(t, "rsp_valid", int'(rsp_valid), int'(e_valid));
        check(t, "rsp_fault", int'(rsp_fault), e_fault);
        check("R9", "rsp_err", int'(rsp_err), int'(e_fault != 0));
        check(t, "rsp_addr", int'(rsp_addr), e_addr);
    endtask

    task automatic load(input int seg, input int lim, input int base, input bit live, input bit ro);
        step(1'b0, 1'b0, 0, 0, 1'b1, seg, lim, base, live, ro, "R2");
    endtask

    task automatic look(input bit w, input int seg, input int off, input string tag);
        step(1'b1, w, seg, off, 1'b0, 0, 0, 0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < NSEG; i++) begin
            m_lim[i] = 0; m_base[i] = 0; m_live[i] = 0; m_ro[i] = 0;
        end
        repeat (3) @(negedge clk);
        check("R1", "rsp_valid in reset", int'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "rsp_valid after reset", int'(rsp_valid), 0);
        for (int s = 0; s < NSEG; s++) look(1'b0, s, 0, "R1");

        // R3 worked case and boundaries
        load(3, 2000, 3500, 1'b1, 1'b0);
        look(1'b0, 3, 1123, "R3");
        look(1'b1, 3, 0, "R3");
        look(1'b0, 3, 1999, "R3");
        look(1'b0, 3, 2000, "R4");
        look(1'b1, 3, 4095, "R4");
        // R4 zero limit
        load(1, 0, 100, 1'b1, 1'b0);
        look(1'b0, 1, 0, "R4");
        // R3 carry into top bit: full limit, high base
        load(0, 4096, 65000, 1'b1, 1'b0);
        look(1'b0, 0, 4095, "R3");
        // R5 read-only shared segment
        load(2, 300, 7000, 1'b1, 1'b1);
        look(1'b0, 2, 299, "R5");
        look(1'b1, 2, 299, "R5");
        // R7 priority: limit over protection, absence over limit
        look(1'b1, 2, 300, "R7");
        load(0, 10, 0, 1'b0, 1'b1);
        look(1'b1, 0, 4000, "R7");
        look(1'b0, 0, 5, "R6");
        // R8 same-cycle write and lookup return the old entry
        step(1'b1, 1'b0, 1, 5, 1'b1, 1, 50, 900, 1'b1, 1'b0, "R8");
        look(1'b0, 1, 5, "R8");
        step(1'b1, 1'b1, 2, 10, 1'b1, 2, 300, 7000, 1'b1, 1'b0, "R8");
        look(1'b1, 2, 10, "R8");
        // R2 idle gap then back-to-back
        step(1'b0, 1'b0, 0, 0, 1'b0, 0, 0, 0, 1'b0, 1'b0, "R2");
        look(1'b0, 3, 1, "R2");
        look(1'b0, 3, 2, "R2");

        for (int k = 0; k < 400; k++) begin
            step(1'($urandom), 1'($urandom), int'($urandom_range(NSEG - 1)),
                 int'($urandom_range(4095)), ($urandom_range(3) == 0),
                 int'($urandom_range(NSEG - 1)), int'($urandom_range(4096)),
                 int'($urandom_range(65535)), ($urandom_range(4) != 0), 1'($urandom), "");
        end

        summary();
        $finish;
    end

endmodule